// File: doc/BRIEF.md
# Double-buffered PWM reload controller

A two-output PWM generator whose timing is held in two register layers. Software writes a prescaler, a counter modulus and one pulse width per pin into holding registers over a small synchronous register bus. Those values reach the active buffers that drive the counter and the comparators only at a PWM reload, and only while a load-okay bit is pending. Load-okay is armed by a read of the control register that returns it as zero, and it is cleared by hardware when the load completes.

A single control register carries enable, reload-interrupt enable and load-okay. All three only work while a multi-timebase mode bit in the configuration register is set. A reload flag in a status register can raise an interrupt. Each pin also has a software override that forces a fixed level whether or not the generator runs.

Register map (3-bit address, 8-bit data): 0 control, 1 configuration, 2 status, 3 prescaler, 4 modulus, 5 width of pin 0, 6 width of pin 1. Reads of addresses 3 to 6 return the holding values.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: While configuration bit 0 (mode) is clear, the control register reads as zero, ignores writes, and its enable, interrupt-enable and load-okay bits are cleared.
- R2: Control register layout: bit 7 enable, bit 1 interrupt enable, bit 0 load-okay, bits 6..2 read zero. All three bits are zero after reset.
- R3: The values at addresses 3 to 6 move to the active buffers only at a reload while load-okay is set. Writing the holding registers alone changes neither the period nor the pulse widths.
- R4: Writing 1 to control bit 0 sets load-okay only if an earlier control read returned it as 0 with no control write in between. Any other write of 1 leaves a clear load-okay clear.
- R5: Load-okay clears by itself at the reload that commits the held values.
- R6: Writing 0 to control bit 0 before a reload clears load-okay, and the held values are not committed.
- R7: A control write that sets load-okay leaves enable unchanged, even if bit 7 is 1.
- R8: With enable clear the counter stays at zero and both pins are low. If configuration bit 1+k (override enable) is set, pin k follows configuration bit 3+k instead, whatever the enable state.
- R9: While enabled, the count advances once every (prescaler+1) clocks from 0 up to the modulus and then wraps to 0. Both the wrap and the first cycle after enable are reloads. Pin k is high while the count is below width k.
- R10: Status bit 0 (reload flag) sets at every reload and is cleared by writing 1 to status bit 0. A reload in the same cycle wins over the clear.
- R11: irq_o is high exactly when the reload flag and the interrupt enable are both set.
- R12: rd_i captures the addressed register into rdata_o on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Reload interrupt request |
| pwm_o | output | 2 | PWM pin outputs |

## Verification
The hardest case to reach is the load-okay handshake racing the generator. This means a pending load that software withdraws before any reload can use it, and a write that sets load-okay and enable together. The stimulus makes these cases deterministic by stopping the generator first, so that the only reload is the start-up one. The bench then reads back the control register and measures the pin period between rising edges, which shows whether the old or the new modulus is active.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;
  localparam int unsigned AW = 3;
  localparam int unsigned DW = 8;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_CFG  = 3'd1;
  localparam logic [AW-1:0] A_STAT = 3'd2;
  localparam logic [AW-1:0] A_PRE  = 3'd3;
  localparam logic [AW-1:0] A_MOD  = 3'd4;
  localparam logic [AW-1:0] A_W0   = 3'd5;

  localparam int unsigned CTRL_EN   = 7;
  localparam int unsigned CTRL_IRQ  = 1;
  localparam int unsigned CTRL_LDOK = 0;
  localparam int unsigned CFG_MODE  = 0;
endpackage

// File: rtl/pwm_reload_regs.sv
module pwm_reload_regs
  import pwm_reload_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned PRE_W  = 3,
  parameter int unsigned N_PINS = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [AW-1:0]                 addr_i,
  input  logic [DW-1:0]                 wdata_i,
  input  logic                          wr_i,
  input  logic                          rd_i,
  output logic [DW-1:0]                 rdata_o,
  input  logic                          reload_i,
  output logic                          en_o,
  output logic                          irq_o,
  output logic [N_PINS-1:0]             ovr_en_o,
  output logic [N_PINS-1:0]             ovr_val_o,
  output logic [PRE_W-1:0]              pre_o,
  output logic [CNT_W-1:0]              mod_o,
  output logic [N_PINS-1:0][CNT_W-1:0]  width_o
);
  localparam int unsigned OVR_EN_LSB  = 1;
  localparam int unsigned OVR_VAL_LSB = 1 + N_PINS;

  logic mode_q, en_q, irq_en_q, ldok_q, armed_q, flag_q;
  logic [N_PINS-1:0] ovr_en_q, ovr_val_q;
  logic [PRE_W-1:0] pre_h, pre_a;
  logic [CNT_W-1:0] mod_h, mod_a;
  logic [N_PINS-1:0][CNT_W-1:0] w_h, w_a;
  logic [DW-1:0] rd_mux;

  logic wr_ctrl, rd_ctrl, wr_stat, set_ldok, load;
  assign wr_ctrl  = wr_i && addr_i == A_CTRL;
  assign rd_ctrl  = rd_i && addr_i == A_CTRL;
  assign wr_stat  = wr_i && addr_i == A_STAT;
  assign set_ldok = wr_ctrl && mode_q && wdata_i[CTRL_LDOK] && !ldok_q && armed_q;
  assign load     = reload_i && ldok_q;

  // control bits: gated by mode, armed load-okay handshake
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      irq_en_q <= 1'b0;
      ldok_q   <= 1'b0;
      armed_q  <= 1'b0;
    end else if (!mode_q) begin
      en_q     <= 1'b0;
      irq_en_q <= 1'b0;
      ldok_q   <= 1'b0;
      armed_q  <= 1'b0;
    end else if (wr_ctrl) begin
      ldok_q   <= wdata_i[CTRL_LDOK] & (ldok_q | armed_q);
      en_q     <= set_ldok ? en_q : wdata_i[CTRL_EN];
      irq_en_q <= wdata_i[CTRL_IRQ];
      armed_q  <= 1'b0;
    end else begin
      if (load) ldok_q <= 1'b0;
      if (rd_ctrl && !ldok_q) armed_q <= 1'b1;
    end
  end

  // configuration, holding and active buffers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= 1'b0;
      ovr_en_q  <= '0;
      ovr_val_q <= '0;
      pre_h     <= '0;
      mod_h     <= '0;
      w_h       <= '0;
      pre_a     <= '0;
      mod_a     <= '0;
      w_a       <= '0;
    end else begin
      if (wr_i && addr_i == A_CFG) begin
        mode_q    <= wdata_i[CFG_MODE];
        ovr_en_q  <= wdata_i[OVR_EN_LSB +: N_PINS];
        ovr_val_q <= wdata_i[OVR_VAL_LSB +: N_PINS];
      end
      if (wr_i && addr_i == A_PRE) pre_h <= wdata_i[PRE_W-1:0];
      if (wr_i && addr_i == A_MOD) mod_h <= wdata_i[CNT_W-1:0];
      for (int k = 0; k < N_PINS; k++) begin
        if (wr_i && addr_i == AW'(A_W0 + k)) w_h[k] <= wdata_i[CNT_W-1:0];
      end
      if (load) begin
        pre_a <= pre_h;
        mod_a <= mod_h;
        w_a   <= w_h;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (reload_i) flag_q <= 1'b1;
    else if (wr_stat && wdata_i[0]) flag_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_CTRL: begin
        rd_mux[CTRL_EN]   = en_q;
        rd_mux[CTRL_IRQ]  = irq_en_q;
        rd_mux[CTRL_LDOK] = ldok_q;
      end
      A_CFG: begin
        rd_mux[CFG_MODE]                = mode_q;
        rd_mux[OVR_EN_LSB +: N_PINS]    = ovr_en_q;
        rd_mux[OVR_VAL_LSB +: N_PINS]   = ovr_val_q;
      end
      A_STAT: rd_mux[0] = flag_q;
      A_PRE:  rd_mux[PRE_W-1:0] = pre_h;
      A_MOD:  rd_mux[CNT_W-1:0] = mod_h;
      default: begin
        for (int k = 0; k < N_PINS; k++) begin
          if (addr_i == AW'(A_W0 + k)) rd_mux[CNT_W-1:0] = w_h[k];
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  assign en_o      = en_q;
  assign irq_o     = flag_q & irq_en_q;
  assign ovr_en_o  = ovr_en_q;
  assign ovr_val_o = ovr_val_q;
  assign pre_o     = pre_a;
  assign mod_o     = mod_a;
  assign width_o   = w_a;

  p_ctrl_cleared_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |=> (!en_q && !ldok_q && !irq_en_q));
  p_active_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mod_a) |-> $past(load));
  p_prescale_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pre_a) |-> $past(load));
  p_ldok_armed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ldok_q) |-> $past(armed_q));
  p_ldok_autoclr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !wr_ctrl) |=> !ldok_q);
  p_en_blocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_ldok && !en_q) |=> !en_q);
  p_flag_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> flag_q);
endmodule

// File: rtl/pwm_reload_timebase.sv
module pwm_reload_timebase #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PRE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             reload_o
);
  logic             en_d;
  logic [PRE_W-1:0] pdiv;
  logic [CNT_W-1:0] cnt;
  logic             tick, wrap;

  assign tick     = pdiv == pre_i;
  assign wrap     = tick && cnt == mod_i;
  // start-up cycle counts as a reload so pending values apply from the first period
  assign reload_o = en_i && (!en_d || wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d <= 1'b0;
      pdiv <= '0;
      cnt  <= '0;
    end else begin
      en_d <= en_i;
      if (!en_i || !en_d) begin
        pdiv <= '0;
        cnt  <= '0;
      end else if (tick) begin
        pdiv <= '0;
        cnt  <= wrap ? '0 : cnt + 1'b1;
      end else begin
        pdiv <= pdiv + 1'b1;
      end
    end
  end

  assign cnt_o = cnt;

  p_cnt_in_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt <= mod_i);
  p_stopped_at_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt == '0);
endmodule

// File: rtl/pwm_reload_out.sv
module pwm_reload_out #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned N_PINS = 2
) (
  input  logic                         en_i,
  input  logic [CNT_W-1:0]             cnt_i,
  input  logic [N_PINS-1:0][CNT_W-1:0] width_i,
  input  logic [N_PINS-1:0]            ovr_en_i,
  input  logic [N_PINS-1:0]            ovr_val_i,
  output logic [N_PINS-1:0]            pwm_o
);
  for (genvar k = 0; k < N_PINS; k++) begin : g_pin
    assign pwm_o[k] = ovr_en_i[k] ? ovr_val_i[k] : (en_i && cnt_i < width_i[k]);
  end
endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
  import pwm_reload_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned PRE_W  = 3,
  parameter int unsigned N_PINS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o,
  output logic [N_PINS-1:0] pwm_o
);
  logic                         en, reload;
  logic [N_PINS-1:0]            ovr_en, ovr_val;
  logic [PRE_W-1:0]             pre;
  logic [CNT_W-1:0]             modulus, cnt;
  logic [N_PINS-1:0][CNT_W-1:0] width;

  pwm_reload_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .N_PINS(N_PINS)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_i, .rd_i, .rdata_o,
    .reload_i (reload),
    .en_o     (en),
    .irq_o,
    .ovr_en_o (ovr_en),
    .ovr_val_o(ovr_val),
    .pre_o    (pre),
    .mod_o    (modulus),
    .width_o  (width)
  );

  pwm_reload_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tb (
    .clk_i, .rst_ni,
    .en_i    (en),
    .pre_i   (pre),
    .mod_i   (modulus),
    .cnt_o   (cnt),
    .reload_o(reload)
  );

  pwm_reload_out #(.CNT_W(CNT_W), .N_PINS(N_PINS)) u_out (
    .en_i     (en),
    .cnt_i    (cnt),
    .width_i  (width),
    .ovr_en_i (ovr_en),
    .ovr_val_i(ovr_val),
    .pwm_o
  );
endmodule

// File: tb/pwm_reload_ctrl_tb_top.sv
module pwm_reload_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CTRL = 0, CFG = 1, STAT = 2, PRE = 3, MODR = 4, W0 = 5, W1 = 6;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic       irq_o;
  logic [1:0] pwm_o;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwm_reload_ctrl dut_i (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_i, .rd_i, .rdata_o, .irq_o, .pwm_o
  );

  // behavioural reference model
  bit m_mode, m_en, m_irqen, m_ldok, m_armed, m_flag, m_enq;
  bit m_oen[2], m_oval[2];
  int h_pre, h_mod, h_w[2], a_pre, a_mod, a_w[2];
  int m_cnt, m_pdiv, m_rdata;

  function automatic int ctrl_val();
    return m_mode ? ((m_en ? 128 : 0) + (m_irqen ? 2 : 0) + (m_ldok ? 1 : 0)) : 0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_en = 0; m_irqen = 0; m_ldok = 0; m_armed = 0; m_flag = 0; m_enq = 0;
      m_oen = '{0, 0}; m_oval = '{0, 0};
      h_pre = 0; h_mod = 0; h_w = '{0, 0}; a_pre = 0; a_mod = 0; a_w = '{0, 0};
      m_cnt = 0; m_pdiv = 0; m_rdata = 0;
    end else begin
      bit rl, setl, n_en, n_irq, n_ldok, n_arm, n_flag;
      int n_cnt, n_pdiv, rv, a, d;
      a = int'(addr_i); d = int'(wdata_i);
      rl = m_en && (!m_enq || (m_pdiv == a_pre && m_cnt == a_mod));
      if (!m_en || !m_enq) begin n_cnt = 0; n_pdiv = 0; end
      else if (m_pdiv == a_pre) begin n_pdiv = 0; n_cnt = (m_cnt == a_mod) ? 0 : m_cnt + 1; end
      else begin n_pdiv = m_pdiv + 1; n_cnt = m_cnt; end
      n_en = m_en; n_irq = m_irqen; n_ldok = m_ldok; n_arm = m_armed;
      if (!m_mode) begin n_en = 0; n_irq = 0; n_ldok = 0; n_arm = 0; end
      else if (wr_i && a == CTRL) begin
        setl = d[0] && !m_ldok && m_armed;
        n_ldok = d[0] && (m_ldok || m_armed);
        n_en = setl ? m_en : d[7];
        n_irq = d[1];
        n_arm = 0;
      end else begin
        if (rl && m_ldok) n_ldok = 0;
        if (rd_i && a == CTRL && !m_ldok) n_arm = 1;
      end
      n_flag = rl ? 1 : ((wr_i && a == STAT && d[0]) ? 0 : m_flag);
      if (rd_i) begin
        case (a)
          CTRL: rv = ctrl_val();
          CFG:  rv = (m_mode ? 1 : 0) + (m_oen[0] ? 2 : 0) + (m_oen[1] ? 4 : 0)
                   + (m_oval[0] ? 8 : 0) + (m_oval[1] ? 16 : 0);
          STAT: rv = m_flag ? 1 : 0;
          PRE:  rv = h_pre;
          MODR: rv = h_mod;
          W0:   rv = h_w[0];
          W1:   rv = h_w[1];
          default: rv = 0;
        endcase
        m_rdata = rv;
      end
      if (rl && m_ldok) begin a_pre = h_pre; a_mod = h_mod; a_w = h_w; end
      if (wr_i) begin
        case (a)
          CFG: begin m_mode = d[0]; m_oen[0] = d[1]; m_oen[1] = d[2]; m_oval[0] = d[3]; m_oval[1] = d[4]; end
          PRE: h_pre = d % 8;
          MODR: h_mod = d;
          W0: h_w[0] = d;
          W1: h_w[1] = d;
          default: ;
        endcase
      end
      m_en = n_en; m_irqen = n_irq; m_ldok = n_ldok; m_armed = n_arm; m_flag = n_flag;
      m_enq = rl ? 1 : m_en && m_enq;
      m_enq = n_en ? (m_enq | 1'b0) : m_enq;
      m_cnt = n_cnt; m_pdiv = n_pdiv;
    end
  end

  // en_q of the model tracks the previous enable
  bit m_en_prev;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_en_prev <= 0;
    else m_en_prev <= dut_en_ref();
  end
  function automatic bit dut_en_ref();
    return m_en;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni) begin
      int ep;
      ep = 0;
      for (int k = 0; k < 2; k++) begin
        bit b;
        b = m_oen[k] ? m_oval[k] : (m_en && m_cnt < a_w[k]);
        if (b) ep += (1 << k);
      end
      check(int'(pwm_o) == ep, "R9 pins", int'(pwm_o), ep);
      check(irq_o == (m_flag && m_irqen), "R11 irq", int'(irq_o), int'(m_flag && m_irqen));
      check(int'(rdata_o) == m_rdata, "R12 rdata", int'(rdata_o), m_rdata);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    addr_i = 3'(a); wdata_i = 8'(d); wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk_i);
    addr_i = 3'(a); rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    check(int'(rdata_o) == exp, tag, int'(rdata_o), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic period0(output int p);
    int n;
    while (pwm_o[0]) @(negedge clk_i);
    while (!pwm_o[0]) @(negedge clk_i);
    n = 0;
    while (pwm_o[0]) begin @(negedge clk_i); n++; end
    while (!pwm_o[0]) begin @(negedge clk_i); n++; end
    p = n;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int p;
    idle(3);
    rst_ni = 1'b1;
    // R2: reset state
    rd(CTRL, 0, "R2 ctrl after reset");
    check(pwm_o == 2'b00, "R8 pins after reset", int'(pwm_o), 0);
    // R1: mode clear blocks writes
    wr(CTRL, 'h83);
    rd(CTRL, 0, "R1 ctrl with mode clear");
    wr(CFG, 1);
    wr(PRE, 0); wr(MODR, 9); wr(W0, 3); wr(W1, 7);
    rd(MODR, 9, "R3 holding modulus readback");
    // R4: write of one without prior zero read
    wr(CTRL, 1);
    rd(CTRL, 0, "R4 unarmed set ignored");
    wr(CTRL, 1);
    rd(CTRL, 1, "R4 armed set");
    check(pwm_o == 2'b00, "R3 no commit while stopped", int'(pwm_o), 0);
    // R5: start reload commits and clears load-okay
    wr(CTRL, 'h81);
    idle(3);
    rd(CTRL, 'h80, "R5 auto clear");
    idle(40);
    period0(p);
    check(p == 10, "R9 period mod 9 pre 0", p, 10);
    // R10: flag clear
    wr(CTRL, 0);
    rd(STAT, 1, "R10 flag set by reloads");
    wr(STAT, 1);
    rd(STAT, 0, "R10 flag cleared");
    // R7: load-okay set with enable in one write
    rd(CTRL, 0, "R7 arm read");
    wr(CTRL, 'h81);
    rd(CTRL, 'h01, "R7 enable ignored");
    check(pwm_o == 2'b00, "R8 pins low when stopped", int'(pwm_o), 0);
    wr(CTRL, 'h83);
    idle(25);
    check(irq_o == 1'b1, "R11 irq with enable", int'(irq_o), 1);
    // R6: withdrawn load never commits
    wr(CTRL, 'h02);
    wr(MODR, 4);
    rd(CTRL, 'h02, "R6 arm read");
    wr(CTRL, 'h03);
    wr(CTRL, 'h02);
    rd(CTRL, 'h02, "R6 load-okay withdrawn");
    wr(CTRL, 'h82);
    idle(5);
    period0(p);
    check(p == 10, "R6 old modulus kept", p, 10);
    // R3/R9: new prescaler and modulus at next reload
    rd(CTRL, 'h82, "R3 arm read");
    wr(PRE, 1); wr(MODR, 5);
    wr(CTRL, 'h83);
    idle(30);
    rd(CTRL, 'h82, "R5 cleared after wrap load");
    period0(p);
    check(p == 12, "R9 period mod 5 pre 1", p, 12);
    // R8: override
    wr(CFG, 'h0B);
    wr(CTRL, 'h02);
    idle(3);
    check(pwm_o == 2'b01, "R8 override while stopped", int'(pwm_o), 1);
    // R1: clearing mode clears control bits
    wr(CFG, 0);
    idle(2);
    wr(CFG, 1);
    rd(CTRL, 0, "R1 bits cleared by mode");
    check(irq_o == 1'b0, "R11 irq off without enable", int'(irq_o), 0);
    rd(W1, 7, "R12 width readback");
    idle(5);
    summary();
    $finish;
  end
endmodule